// File: doc/BRIEF.md
# SDRAM Command Legality Monitor

This block sits passively on the command pins of a synchronous DRAM interface. It does not drive the memory. It decodes the command on every clock edge from chip select, the three strobes RAS, CAS and WE, clock enable, the bank address and address bit 10. It checks that command against a model of the device: the state of each of the four banks, a device-wide busy window after refresh or mode setting, and low-power entry. It then advances that model. Each violation is reported one cycle later as a single-cycle flag together with a code that names the broken rule.

All timing limits are parameters in clock cycles: row-to-column delay, row active time, row precharge time, write recovery, refresh cycle time and activate-to-activate spacing. The block judges each command against the state of the bank it addresses. A command that is wrong for one bank can therefore be fine for another. Commands that are found illegal leave the model unchanged.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: Decoding uses {ras_n,cas_n,we_n} while cs_n is low: 111 no-op, 110 burst stop, 101 read, 100 write, 011 activate, 010 precharge, 001 refresh, 000 mode set. cs_n high is deselect, whatever the strobes are. Deselect and no-op are never flagged.
- R2: The result for the command sampled at edge k appears on cmd_bad and err_code after edge k and lasts exactly one cycle. The codes are 0 none, 1 wrong state, 2 row-to-column, 3 row active time, 4 activate spacing, 5 device busy. cmd_bad is high exactly when err_code is nonzero.
- R3: These commands get code 1: a read or write to a bank that is not open, and an activate to a bank that is not idle. A flagged command changes no bank, timer or device state.
- R4: A write with a10 high puts the bank into write recovery. In that state, burst stop, no-op and deselect pass, and read, write, activate or precharge to that bank gets code 1. A precharge with a10 high gets code 1 while any bank is in write recovery. The bank starts precharging T_DPL cycles after the write and is idle from T_DPL+T_RP-1 cycles after it.
- R5: A precharge with a10 low to an open bank, or a read with a10 high, makes that bank idle T_RP cycles later. An activate before then gets code 1. A precharge with a10 high closes every open bank.
- R6: Refresh and mode set need every bank idle; otherwise they get code 1. After an accepted refresh, any command other than deselect or no-op gets code 5 until T_RC cycles have passed. After a mode set the same holds for exactly 2 cycles.
- R7: A read or write issued fewer than T_RCD cycles after the bank's activate gets code 2.
- R8: A precharge, with a10 low or high, that reaches an open bank fewer than T_RAS cycles after that bank's activate gets code 3.
- R9: An activate issued fewer than T_RRD cycles after the previous accepted activate gets code 4.
- R10: Code 5 takes priority over every other check. Code 1 takes priority over the timing codes 2, 3 and 4.
- R11: The device enters low power, and nothing is checked, when all of these hold at one edge: cke was high at the previous edge, cke is low now, every bank is idle and the device is not busy. A refresh at that edge selects self refresh. Checking resumes at the edge after the one where cke is sampled high again. A command is also not checked when cke was low at the previous edge.
- R12: A synchronous active-high rst makes every bank idle, clears all timers and clears both outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock enable seen by the device |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | BA_W | Bank address |
| a10 | input | 1 | Address bit 10 (all-banks / auto-precharge select) |
| cmd_bad | output | 1 | One-cycle pulse for an illegal command |
| err_code | output | 3 | Rule violated, valid with cmd_bad |

## Verification
The hard case is a command that lands in the exact cycle when a timed state ends. One example is an activate to a bank whose write recovery has just turned into precharge, or whose precharge has just finished. Another is a command arriving on the last busy cycle after a refresh. The bench issues the command one cycle early and then on the boundary cycle itself. A behavioural model that keeps absolute cycle deadlines for each bank decides whether the bank is still occupied, and the monitor's code must match the model on every clock.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;
  typedef enum logic [3:0] {
    C_DESL, C_NOP, C_BST, C_RD, C_WR, C_ACT, C_PRE, C_REF, C_MRS
  } cmd_e;

  typedef enum logic [1:0] {B_IDLE, B_OPEN, B_WRAP, B_PCHG} bank_e;

  typedef enum logic [2:0] {
    E_NONE = 3'd0, E_STATE = 3'd1, E_RCD = 3'd2,
    E_RAS = 3'd3, E_RRD = 3'd4, E_BUSY = 3'd5
  } err_e;

  typedef enum logic [1:0] {D_RUN, D_PDN, D_SREF} dev_e;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_mon_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  always_comb begin
    if (cs_n) cmd = C_DESL;
    else begin
      case ({ras_n, cas_n, we_n})
        3'b111:  cmd = C_NOP;
        3'b110:  cmd = C_BST;
        3'b101:  cmd = C_RD;
        3'b100:  cmd = C_WR;
        3'b011:  cmd = C_ACT;
        3'b010:  cmd = C_PRE;
        3'b001:  cmd = C_REF;
        default: cmd = C_MRS;
      endcase
    end
  end
endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
  import sdram_mon_pkg::*;
#(
  parameter int T_RCD = 3,
  parameter int T_RAS = 6,
  parameter int T_RP  = 3,
  parameter int T_DPL = 2,
  parameter int CW    = 5
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  do_act,
  input  logic  do_pre,
  input  logic  do_wrap,
  output bank_e st,
  output logic  rcd_done,
  output logic  ras_done
);
  logic [CW-1:0] tcnt, rcd_c, ras_c;

  assign rcd_done = (rcd_c == '0);
  assign ras_done = (ras_c == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= B_IDLE;
      tcnt  <= '0;
      rcd_c <= '0;
      ras_c <= '0;
    end else begin
      rcd_c <= (rcd_c != '0) ? rcd_c - 1'b1 : '0;
      ras_c <= (ras_c != '0) ? ras_c - 1'b1 : '0;
      if (do_act) begin
        st    <= B_OPEN;
        rcd_c <= CW'(T_RCD - 1);
        ras_c <= CW'(T_RAS - 1);
      end else if (do_pre) begin
        st   <= B_PCHG;
        tcnt <= CW'(T_RP - 1);
      end else if (do_wrap) begin
        st   <= B_WRAP;
        tcnt <= CW'(T_DPL - 1);
      end else begin
        case (st)
          B_WRAP: begin
            if (tcnt <= 1) begin
              st   <= B_PCHG;
              tcnt <= CW'(T_RP - 1);
            end else tcnt <= tcnt - 1'b1;
          end
          B_PCHG: begin
            if (tcnt <= 1) begin
              st   <= B_IDLE;
              tcnt <= '0;
            end else tcnt <= tcnt - 1'b1;
          end
          default: tcnt <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int BA_W  = 2,
  parameter int T_RCD = 3,
  parameter int T_RAS = 6,
  parameter int T_RP  = 3,
  parameter int T_DPL = 2,
  parameter int T_RRD = 2,
  parameter int T_RC  = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cke,
  input  logic            cs_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic [BA_W-1:0] ba,
  input  logic            a10,
  output logic            cmd_bad,
  output logic [2:0]      err_code
);
  localparam int NB    = 1 << BA_W;
  localparam int T_MRD = 2;
  // sum of all limits bounds every single one, so any counter fits
  localparam int TSUM  = T_RCD + T_RAS + T_RP + T_DPL + T_RRD + T_RC + T_MRD;
  localparam int CW    = $clog2(TSUM + 1);

  cmd_e          cmd;
  bank_e         bst [NB];
  logic [NB-1:0] rcd_ok, ras_ok, open_v, wrap_v, idle_v;
  logic [NB-1:0] g_act, g_pre, g_wrap;
  logic [CW-1:0] rrd_c, busy_c;
  dev_e          dev;
  logic          cke_q;
  err_e          err_n;
  logic          act_ok, pre_one, pall, wrap_one, ref_ok, mrs_ok;
  logic          enter_lp, enter_sref, leave_lp, all_idle;
  bank_e         sel;

  sdram_cmd_decode u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
  );

  for (genvar i = 0; i < NB; i++) begin : g_bank
    assign open_v[i] = (bst[i] == B_OPEN);
    assign wrap_v[i] = (bst[i] == B_WRAP);
    assign idle_v[i] = (bst[i] == B_IDLE);
    assign g_act[i]  = act_ok && (ba == BA_W'(i));
    assign g_pre[i]  = (pre_one && (ba == BA_W'(i))) || (pall && open_v[i]);
    assign g_wrap[i] = wrap_one && (ba == BA_W'(i));

    sdram_bank_track #(
      .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP), .T_DPL(T_DPL), .CW(CW)
    ) u_bank (
      .clk(clk), .rst(rst), .do_act(g_act[i]), .do_pre(g_pre[i]),
      .do_wrap(g_wrap[i]), .st(bst[i]), .rcd_done(rcd_ok[i]),
      .ras_done(ras_ok[i])
    );
  end

  assign all_idle = &idle_v;
  assign sel      = bst[ba];

  always_comb begin
    err_n = E_NONE;
    {act_ok, pre_one, pall, wrap_one, ref_ok, mrs_ok} = '0;
    {enter_lp, enter_sref, leave_lp} = '0;
    if (dev != D_RUN) begin
      leave_lp = cke;
    end else if (!cke_q) begin
      err_n = E_NONE;
    end else if (!cke && all_idle && busy_c == '0) begin
      enter_lp   = 1'b1;
      enter_sref = (cmd == C_REF);
    end else if (busy_c != '0) begin
      if (cmd != C_DESL && cmd != C_NOP) err_n = E_BUSY;
    end else begin
      case (cmd)
        C_RD, C_WR: begin
          if (sel != B_OPEN)     err_n = E_STATE;
          else if (!rcd_ok[ba])  err_n = E_RCD;
          else if (a10) begin
            wrap_one = (cmd == C_WR);
            pre_one  = (cmd == C_RD);
          end
        end
        C_ACT: begin
          if (sel != B_IDLE)     err_n = E_STATE;
          else if (rrd_c != '0)  err_n = E_RRD;
          else                   act_ok = 1'b1;
        end
        C_PRE: begin
          if (a10) begin
            if (|wrap_v)                  err_n = E_STATE;
            else if (|(open_v & ~ras_ok)) err_n = E_RAS;
            else                          pall = 1'b1;
          end else if (sel == B_WRAP)     err_n = E_STATE;
          else if (sel == B_OPEN) begin
            if (!ras_ok[ba]) err_n = E_RAS;
            else             pre_one = 1'b1;
          end
        end
        C_REF: begin
          if (!all_idle) err_n = E_STATE;
          else           ref_ok = 1'b1;
        end
        C_MRS: begin
          if (!all_idle) err_n = E_STATE;
          else           mrs_ok = 1'b1;
        end
        default: err_n = E_NONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cke_q    <= 1'b1;
      dev      <= D_RUN;
      rrd_c    <= '0;
      busy_c   <= '0;
      cmd_bad  <= 1'b0;
      err_code <= 3'd0;
    end else begin
      cke_q <= cke;
      if (act_ok)            rrd_c <= CW'(T_RRD - 1);
      else if (rrd_c != '0)  rrd_c <= rrd_c - 1'b1;
      if (ref_ok)            busy_c <= CW'(T_RC - 1);
      else if (mrs_ok)       busy_c <= CW'(T_MRD - 1);
      else if (busy_c != '0) busy_c <= busy_c - 1'b1;
      if (leave_lp)          dev <= D_RUN;
      else if (enter_lp)     dev <= enter_sref ? D_SREF : D_PDN;
      cmd_bad  <= (err_n != E_NONE);
      err_code <= err_n;
    end
  end
endmodule

// File: rtl/sdram_cmd_monitor_chk.sv
module sdram_cmd_monitor_chk #(
  parameter int BA_W  = 2,
  parameter int T_RCD = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            cke,
  input logic            cs_n,
  input logic            ras_n,
  input logic            cas_n,
  input logic            we_n,
  input logic [BA_W-1:0] ba,
  input logic            a10,
  input logic            cmd_bad,
  input logic [2:0]      err_code
);
  localparam logic [2:0] CODE_RCD  = 3'd2;
  localparam logic [2:0] CODE_BUSY = 3'd5;

  logic            nop_now, mrs_now, act_now, rw_now;
  logic            cke_d1, cke_d2, mrs_d1, act_d1;
  logic [BA_W-1:0] ba_d1;

  assign nop_now = cs_n || (ras_n && cas_n && we_n);
  assign mrs_now = !cs_n && !ras_n && !cas_n && !we_n;
  assign act_now = !cs_n && !ras_n && cas_n && we_n;
  assign rw_now  = !cs_n && ras_n && !cas_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      {cke_d1, cke_d2, mrs_d1, act_d1} <= '0;
      ba_d1 <= '0;
    end else begin
      cke_d1 <= cke;
      cke_d2 <= cke_d1;
      mrs_d1 <= mrs_now;
      act_d1 <= act_now;
      ba_d1  <= ba;
    end
  end

  AST_DESL_QUIET: assert property (@(posedge clk) disable iff (rst) (cs_n |=> !cmd_bad)); // R1
  AST_FLAG_CODE_AGREE: assert property (@(posedge clk) disable iff (rst) (cmd_bad == (err_code != 3'd0))); // R2
  AST_CODE_KNOWN: assert property (@(posedge clk) disable iff (rst) (err_code <= CODE_BUSY)); // R2
  AST_MRS_HOLDOFF: assert property (@(posedge clk) disable iff (rst) (mrs_d1 && cke_d1 && cke_d2 && !cmd_bad && !nop_now |=> cmd_bad && err_code == CODE_BUSY)); // R6

  if (T_RCD > 1) begin : g_rcd
    AST_RCD_EARLY: assert property (@(posedge clk) disable iff (rst) (act_d1 && cke_d1 && cke_d2 && !cmd_bad && rw_now && ba == ba_d1 |=> err_code == CODE_RCD)); // R7
  end

  logic unused_a10;
  assign unused_a10 = a10;
endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_chk #(.BA_W(BA_W), .T_RCD(T_RCD)) u_chk (
  .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .ba(ba), .a10(a10), .cmd_bad(cmd_bad), .err_code(err_code)
);

// File: tb/sim_sdram_cmd_monitor.sv
`timescale 1ns/1ps
module sim_sdram_cmd_monitor;
  localparam int T_RCD = 3, T_RAS = 6, T_RP = 3, T_DPL = 2, T_RRD = 2, T_RC = 8;
  // command numbering used by the bench
  localparam int DESL = 0, NOP = 1, BST = 2, RD = 3, WR = 4, ACT = 5, PRE = 6, REF = 7, MRS = 8;

  logic clk = 1'b0, rst = 1'b1, cke = 1'b1;
  logic cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
  logic [1:0] ba = 2'd0;
  logic cmd_bad;
  logic [2:0] err_code;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // model state: 0 idle, 1 open, 2 write recovery, 3 precharging
  int st[4], bend[4], rcd_at[4], ras_at[4];
  int rrd_at, busy_at, mode, ckep, t;

  always #2 clk = ~clk;

  sdram_cmd_monitor #(
    .BA_W(2), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP),
    .T_DPL(T_DPL), .T_RRD(T_RRD), .T_RC(T_RC)
  ) u0 (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10),
    .cmd_bad(cmd_bad), .err_code(err_code)
  );

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      st[i] = 0; bend[i] = 0; rcd_at[i] = 0; ras_at[i] = 0;
    end
    rrd_at = 0; busy_at = 0; mode = 0; ckep = 1; t = 0;
  endtask

  task automatic model(input int c, input int b, input bit a, input bit k, output int e);
    bit all_idle, any_wr, ras_early;
    e = 0;
    for (int i = 0; i < 4; i++) begin
      if (st[i] == 2 && t >= bend[i]) begin st[i] = 3; bend[i] = bend[i] + T_RP - 1; end
      if (st[i] == 3 && t >= bend[i]) st[i] = 0;
    end
    all_idle = 1; any_wr = 0; ras_early = 0;
    for (int i = 0; i < 4; i++) begin
      if (st[i] != 0) all_idle = 0;
      if (st[i] == 2) any_wr = 1;
      if (st[i] == 1 && t < ras_at[i]) ras_early = 1;
    end
    if (mode != 0) begin
      if (k) mode = 0;
    end else if (ckep == 0) begin
      e = 0;
    end else if (!k && all_idle && t >= busy_at) begin
      mode = (c == REF) ? 2 : 1;
    end else if (t < busy_at) begin
      if (c > NOP) e = 5;
    end else begin
      case (c)
        RD, WR: begin
          if (st[b] != 1) e = 1;
          else if (t < rcd_at[b]) e = 2;
          else if (a) begin
            if (c == WR) begin st[b] = 2; bend[b] = t + T_DPL; end
            else begin st[b] = 3; bend[b] = t + T_RP; end
          end
        end
        ACT: begin
          if (st[b] != 0) e = 1;
          else if (t < rrd_at) e = 4;
          else begin
            st[b] = 1; rcd_at[b] = t + T_RCD; ras_at[b] = t + T_RAS; rrd_at = t + T_RRD;
          end
        end
        PRE: begin
          if (a) begin
            if (any_wr) e = 1;
            else if (ras_early) e = 3;
            else for (int i = 0; i < 4; i++)
              if (st[i] == 1) begin st[i] = 3; bend[i] = t + T_RP; end
          end else if (st[b] == 2) e = 1;
          else if (st[b] == 1) begin
            if (t < ras_at[b]) e = 3;
            else begin st[b] = 3; bend[b] = t + T_RP; end
          end
        end
        REF: if (!all_idle) e = 1; else busy_at = t + T_RC;
        MRS: if (!all_idle) e = 1; else busy_at = t + 2;
        default: e = 0;
      endcase
    end
    ckep = k;
    t++;
  endtask

  task automatic check(input string tag, input int exp_e);
    checks++;
    if (cmd_bad !== (exp_e != 0) || err_code !== exp_e[2:0]) begin
      errors++;
      $display("FAIL %s t=%0d: got bad=%0b code=%0d, expected bad=%0b code=%0d",
               tag, t, cmd_bad, err_code, exp_e != 0, exp_e);
    end
  endtask

  task automatic step(input int c, input int b, input bit a, input bit k, input string tag);
    int e;
    if (c == DESL) begin
      cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b000;
    end else begin
      cs_n = 1'b0; {ras_n, cas_n, we_n} = 3'(8 - c);
    end
    ba = 2'(b); a10 = a; cke = k;
    model(c, b, a, k, e);
    @(posedge clk); #1;
    check(tag, e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(NOP, 0, 1'b0, 1'b1, "R1");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    check("R12", 0);
    step(NOP, 0, 0, 1, "R1");
    step(DESL, 2, 1, 1, "R1");
    step(RD, 0, 0, 1, "R3");
    // row timing
    step(ACT, 0, 0, 1, "R9");
    step(ACT, 1, 0, 1, "R9");
    step(RD, 0, 0, 1, "R7");
    step(RD, 0, 0, 1, "R7");
    step(PRE, 0, 0, 1, "R8");
    step(ACT, 0, 0, 1, "R3");
    step(PRE, 0, 0, 1, "R8");
    step(ACT, 0, 0, 1, "R5");
    step(NOP, 0, 0, 1, "R1");
    step(ACT, 0, 0, 1, "R5");
    step(ACT, 1, 0, 1, "R9");
    step(ACT, 1, 0, 1, "R9");
    // write recovery with auto precharge, exit boundary
    idle(2);
    step(ACT, 2, 0, 1, "R4");
    idle(3);
    step(WR, 2, 1, 1, "R4");
    step(BST, 2, 0, 1, "R4");
    step(PRE, 3, 1, 1, "R4");
    step(ACT, 2, 0, 1, "R4");
    step(ACT, 2, 0, 1, "R4");
    step(ACT, 2, 0, 1, "R4");
    // refresh and mode set hold-off
    step(REF, 0, 0, 1, "R6");
    step(PRE, 0, 1, 1, "R8");
    idle(6);
    step(PRE, 0, 1, 1, "R5");
    idle(3);
    step(REF, 0, 0, 1, "R6");
    step(ACT, 0, 0, 1, "R10");
    idle(5);
    step(ACT, 0, 0, 1, "R6");
    step(ACT, 0, 0, 1, "R6");
    idle(6);
    step(PRE, 0, 0, 1, "R5");
    idle(3);
    step(MRS, 0, 0, 1, "R6");
    step(RD, 1, 0, 1, "R6");
    step(ACT, 1, 0, 1, "R6");
    idle(6);
    step(PRE, 1, 0, 1, "R5");
    idle(3);
    // power down and self refresh
    step(NOP, 0, 0, 0, "R11");
    step(RD, 0, 0, 0, "R11");
    step(RD, 0, 0, 1, "R11");
    step(RD, 0, 0, 1, "R11");
    step(REF, 0, 0, 0, "R11");
    step(MRS, 0, 0, 0, "R11");
    step(NOP, 0, 0, 1, "R11");
    step(RD, 2, 0, 1, "R11");
    // cke low with a bank open
    step(ACT, 3, 0, 1, "R11");
    step(NOP, 0, 0, 0, "R11");
    step(RD, 3, 0, 0, "R11");
    step(NOP, 0, 0, 1, "R11");
    step(RD, 3, 0, 1, "R11");
    // reset in the middle of activity
    rst = 1'b1;
    @(posedge clk); #1;
    check("R12", 0);
    rst = 1'b0;
    model_reset();
    step(RD, 3, 0, 1, "R12");
    // random traffic against the model
    for (int i = 0; i < 600; i++) begin
      int c;
      c = $urandom_range(0, 8);
      step(c, $urandom_range(0, 3), 1'($urandom_range(0, 1)),
           ($urandom_range(0, 11) != 0), "R10");
    end
    finish_run();
  end
endmodule